// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the protocol engine of a two-wire serial memory slave that sits in front of a 2 KB byte-addressed store. A bus conditioner ahead of it turns the raw clock and data lines into one-cycle event strobes: a START, a STOP, a sampled data bit taken on the rising clock, and a falling-clock strobe. The engine decodes the control byte, keeps an 11-bit address pointer, answers with acknowledge bits and read data through an open-drain pull-down enable, and hands write bytes to an external page buffer. It asks for a programming cycle when the master ends a write with STOP.

The control byte carries a fixed device code in bits 7:4, a block number in bits 3:1 that becomes the top three bits of the word address, and the read/write selector in bit 0. While the external programming cycle is busy the engine stays silent, so a master can poll it with control bytes until it answers. A write-protect input stops buffer writes and programming requests but leaves reads alone.

States: `S_IDLE` (bus free), `S_CTRL` (receiving the control byte), `S_CACK` (acknowledging it), `S_ADDR` / `S_AACK` (word address and its acknowledge), `S_WDAT` / `S_WACK` (write data and its acknowledge), `S_RDAT` / `S_RACK` (sending a byte, then sampling the master's acknowledge), `S_SKIP` (released, waiting for START). Transitions: START from any state goes to `S_CTRL`; STOP from any state goes to `S_IDLE`. `S_CTRL`→`S_CACK` on a matching code with no programming cycle running, else →`S_SKIP`. `S_CACK`→`S_RDAT` for a read, →`S_ADDR` for a write. `S_ADDR`→`S_AACK` and `S_WDAT`→`S_WACK` when idle, else →`S_SKIP`. `S_AACK`/`S_WACK`→`S_WDAT`. `S_RDAT`→`S_RACK` after eight bits. `S_RACK`→`S_RDAT` on a master acknowledge (bit 0), →`S_SKIP` on a missing acknowledge (bit 1).

Top module: `eeprom_bus_slave`

## Requirements
- R1: A control byte with bits 7:4 equal to DEV_CODE (default 1010b) is acknowledged; bit 0 set to 1 selects a read and 0 selects a write.
- R2: A control byte with any other code is not acknowledged. The data line stays released and no buffer write occurs until the next START, after which a valid control byte is accepted again.
- R3: Control byte bits 3:1 become address bits 10:8. On a write, the next byte becomes address bits 7:0.
- R4: For each accepted byte, the pull-down enable rises at the falling clock after the eighth bit and falls at the falling clock after the ninth. It is low after reset.
- R5: Each write data byte produces one buffer write strobe carrying the current address and the byte. After it, only the low PAGE_BITS address bits increment and they wrap inside the page.
- R6: While prog_busy is high, no byte is acknowledged, including the control byte. The engine then ignores the bus until START.
- R7: A STOP that follows at least one write data byte pulses prog_start one cycle after the STOP strobe. A STOP without a data byte does not.
- R8: A read that follows a STOP returns the byte at the last accessed address plus one, inside the block named by the control byte.
- R9: A repeated START after the word-address acknowledge keeps the loaded address for the following read and requests no programming.
- R10: In a read, a master acknowledge fetches the next byte, and the 11-bit pointer wraps from 7FFh to 000h. A missing acknowledge releases the data line and leaves later bytes unacknowledged until START.
- R11: With wp high, write bytes are still acknowledged but give no buffer write and no prog_start, and reads work normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | START condition strobe |
| ev_stop | input | 1 | STOP condition strobe |
| ev_bit | input | 1 | Data bit sampled on rising bus clock |
| bit_in | input | 1 | Value of the sampled bit |
| ev_fall | input | 1 | Falling bus clock strobe |
| prog_busy | input | 1 | Programming cycle in progress |
| wp | input | 1 | Write protect |
| mem_rdata | input | 8 | Read data at mem_addr |
| sda_low | output | 1 | Open-drain pull-down enable for the data line |
| mem_addr | output | 11 | Address pointer, used as read address |
| buf_we | output | 1 | Page buffer write strobe |
| buf_addr | output | 11 | Page buffer write address |
| buf_data | output | 8 | Page buffer write data |
| prog_start | output | 1 | Request to start a programming cycle |

## Verification
The bench builds the block with its defaults: DEV_CODE of 1010b and a 16-byte page (PAGE_BITS = 4). With these values a three-byte write that starts two bytes before a page end shows the in-page wrap. A random read at 7FEh followed by two acknowledged reads takes the pointer across the top of the 11-bit space. A behavioural byte array in the bench answers reads and takes each buffer write, so the scoreboard compares read data and write strobes against values the bench computes itself.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CACK,
        S_ADDR,
        S_AACK,
        S_WDAT,
        S_WACK,
        S_RDAT,
        S_RACK,
        S_SKIP
    } ebs_state_t;

    localparam int BYTE_W = 8;
    localparam int BLK_W  = 3;
    localparam int ADDR_W = BYTE_W + BLK_W;
endpackage

// File: rtl/ebs_shifter.sv
module ebs_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] rx_next,
    output logic         tx_msb,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  rx_q;
    logic [W-1:0]  tx_q;
    logic [CW-1:0] cnt_q;

    assign rx_next = {rx_q[W-2:0], bit_in};
    assign tx_msb  = tx_q[W-1];
    assign last    = (cnt_q == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= '0;
            tx_q  <= '1;
            cnt_q <= '0;
        end else begin
            if (clr) begin
                cnt_q <= '0;
            end else if (shift) begin
                cnt_q <= cnt_q + 1'b1;
                rx_q  <= rx_next;
            end
            if (load) begin
                tx_q <= load_val;
            end else if (shift) begin
                tx_q <= {tx_q[W-2:0], 1'b1};
            end
        end
    end

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R10
endmodule

// File: rtl/ebs_pointer.sv
module ebs_pointer #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_blk,
    input  logic [ADDR_W-9:0] blk,
    input  logic              ld_low,
    input  logic [7:0]        low,
    input  logic              inc_page,
    input  logic              inc_seq,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] PMASK = ADDR_W'((1 << PAGE_BITS) - 1);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_inc;

    assign ptr_inc = ptr_q + 1'b1;
    assign ptr     = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld_blk) begin
            ptr_q[ADDR_W-1:8] <= blk;
        end else if (ld_low) begin
            ptr_q[7:0] <= low;
        end else if (inc_page) begin
            ptr_q <= (ptr_q & ~PMASK) | (ptr_inc & PMASK);
        end else if (inc_seq) begin
            ptr_q <= ptr_inc;
        end
    end

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page |=> ptr_q[ADDR_W-1:PAGE_BITS] == $past(ptr_q[ADDR_W-1:PAGE_BITS])); // R5
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_seq && !ld_blk && !ld_low && !inc_page) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1)); // R10
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
    import ebs_pkg::*;
#(
    parameter logic [3:0] DEV_CODE  = 4'b1010,
    parameter int         PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_bit,
    input  logic              bit_in,
    input  logic              ev_fall,
    input  logic              prog_busy,
    input  logic              wp,
    input  logic [7:0]        mem_rdata,
    output logic              sda_low,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              prog_start
);
    ebs_state_t st, nxt;

    logic              bit_ok;
    logic              shift_st;
    logic              shift;
    logic              last_bit;
    logic              last;
    logic [7:0]        rx_next;
    logic              tx_msb;
    logic              code_ok;
    logic              ctl_rd;
    logic              have_data;
    logic              ld_blk, ld_low, inc_page, rd_load;
    logic              drive;
    logic [ADDR_W-1:0] ptr;

    assign bit_ok   = ev_bit && !ev_start && !ev_stop;
    assign shift_st = (st == S_CTRL) || (st == S_ADDR) || (st == S_WDAT) || (st == S_RDAT);
    assign shift    = bit_ok && shift_st;
    assign last_bit = shift && last;
    assign code_ok  = (rx_next[7:4] == DEV_CODE);

    assign ld_blk   = (st == S_CTRL) && last_bit && code_ok && !prog_busy;
    assign ld_low   = (st == S_ADDR) && last_bit && !prog_busy;
    assign inc_page = (st == S_WDAT) && last_bit && !prog_busy;
    assign rd_load  = bit_ok && (((st == S_CACK) && ctl_rd) || ((st == S_RACK) && !bit_in));

    assign mem_addr = ptr;

    ebs_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ev_start || ev_stop),
        .shift    (shift),
        .bit_in   (bit_in),
        .load     (rd_load),
        .load_val (mem_rdata),
        .rx_next  (rx_next),
        .tx_msb   (tx_msb),
        .last     (last)
    );

    ebs_pointer #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_blk   (ld_blk),
        .blk      (rx_next[3:1]),
        .ld_low   (ld_low),
        .low      (rx_next),
        .inc_page (inc_page),
        .inc_seq  (rd_load),
        .ptr      (ptr)
    );

    // next-state logic
    always_comb begin
        nxt = st;
        if (ev_start) begin
            nxt = S_CTRL;
        end else if (ev_stop) begin
            nxt = S_IDLE;
        end else if (ev_bit) begin
            unique case (st)
                S_IDLE: nxt = S_IDLE;
                S_CTRL: if (last) nxt = (code_ok && !prog_busy) ? S_CACK : S_SKIP;
                S_CACK: nxt = ctl_rd ? S_RDAT : S_ADDR;
                S_ADDR: if (last) nxt = prog_busy ? S_SKIP : S_AACK;
                S_AACK: nxt = S_WDAT;
                S_WDAT: if (last) nxt = prog_busy ? S_SKIP : S_WACK;
                S_WACK: nxt = S_WDAT;
                S_RDAT: if (last) nxt = S_RACK;
                S_RACK: nxt = bit_in ? S_SKIP : S_RDAT;
                S_SKIP: nxt = S_SKIP;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // data-line drive value for the next low clock phase
    always_comb begin
        unique case (st)
            S_CACK, S_AACK, S_WACK: drive = 1'b1;
            S_RDAT:                 drive = !tx_msb;
            default:                drive = 1'b0;
        endcase
    end

    // outputs and transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low    <= 1'b0;
            ctl_rd     <= 1'b0;
            have_data  <= 1'b0;
            buf_we     <= 1'b0;
            buf_addr   <= '0;
            buf_data   <= '0;
            prog_start <= 1'b0;
        end else begin
            buf_we     <= 1'b0;
            prog_start <= 1'b0;
            if (ev_start || ev_stop) begin
                sda_low <= 1'b0;
            end else if (ev_fall) begin
                sda_low <= drive;
            end
            if (ld_blk) begin
                ctl_rd <= rx_next[0];
            end
            if (ev_start) begin
                have_data <= 1'b0;
            end else if (ev_stop) begin
                have_data  <= 1'b0;
                prog_start <= have_data && !wp;
            end else if (inc_page) begin
                have_data <= 1'b1;
                buf_we    <= !wp;
                buf_addr  <= ptr;
                buf_data  <= rx_next;
            end
        end
    end

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_st && last_bit && prog_busy) |=> (st == S_SKIP)); // R6
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_SKIP) && $past(st == S_SKIP)) |-> !sda_low); // R2
    AST_REL_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_stop) |-> !sda_low); // R4
    AST_PROG_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> ($past(ev_stop) && !$past(wp))); // R7
    AST_WE_NOT_WP: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !$past(wp)); // R11
endmodule

// File: tb/eeprom_bus_slave_tb.sv
module eeprom_bus_slave_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 0, ev_stop = 0, ev_bit = 0, bit_in = 1, ev_fall = 0;
    logic        prog_busy = 0, wp = 0;
    logic [7:0]  mem_rdata;
    logic        sda_low;
    logic [10:0] mem_addr;
    logic        buf_we;
    logic [10:0] buf_addr;
    logic [7:0]  buf_data;
    logic        prog_start;

    logic [7:0]  mem [0:2047];
    logic [18:0] exp_q [$];
    int          total = 0, bad = 0, prog_cnt = 0;

    always #(CLK_P/2) clk = ~clk;
    assign mem_rdata = mem[mem_addr];

    eeprom_bus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_bit(ev_bit), .bit_in(bit_in), .ev_fall(ev_fall),
        .prog_busy(prog_busy), .wp(wp), .mem_rdata(mem_rdata),
        .sda_low(sda_low), .mem_addr(mem_addr), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_data(buf_data), .prog_start(prog_start)
    );

    function automatic logic [7:0] seed(input int a);
        return 8'((a * 5 + 17) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected buffer writes, counts programming requests
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R5 actual=%0h expected=none", {buf_addr, buf_data});
            end else begin
                logic [18:0] e;
                e = exp_q.pop_front();
                if (e != {buf_addr, buf_data}) begin
                    bad++;
                    $display("FAIL R5 actual=%0h expected=%0h", {buf_addr, buf_data}, e);
                end
            end
            mem[buf_addr] <= buf_data;
        end
        if (rst_n && prog_start) prog_cnt++;
    end

    task automatic do_start();
        @(negedge clk) ev_start = 1;
        @(negedge clk) ev_start = 0;
    endtask

    task automatic do_stop();
        @(negedge clk) ev_stop = 1;
        @(negedge clk) ev_stop = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        @(negedge clk) begin bit_in = b; ev_bit = 1; end
        @(negedge clk) begin ev_bit = 0; ev_fall = 1; end
        @(negedge clk) ev_fall = 0;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        ack = sda_low;
        clk_bit(!sda_low);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            d[i] = !sda_low;
            clk_bit(!sda_low);
        end
        clk_bit(!mack);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] d;
        int         pc;
        for (int i = 0; i < 2048; i++) mem[i] = seed(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R4 reset sda", sda_low, 0);
        chk("R5 reset we", buf_we, 0);
        chk("R7 reset prog", prog_start, 0);

        // byte write, block 5 address 3C
        do_start();
        wr_byte(8'hAA, a); chk("R1 ctrl ack", a, 1);
        wr_byte(8'h3C, a); chk("R3 addr ack", a, 1);
        chk("R4 release after ack", sda_low, 0);
        exp_q.push_back({11'h53C, 8'h5A});
        wr_byte(8'h5A, a); chk("R5 data ack", a, 1);
        pc = prog_cnt;
        do_stop();
        chk("R7 prog after stop", prog_cnt - pc, 1);
        chk("R3 write queue drained", exp_q.size(), 0);

        // current-address read from 53D
        do_start();
        wr_byte(8'hAB, a); chk("R1 read ctrl ack", a, 1);
        rd_byte(0, d); chk("R8 current read", d, seed('h53D));
        do_stop();

        // page write wrapping at the 16-byte boundary
        do_start();
        wr_byte(8'hA2, a);
        wr_byte(8'h1E, a);
        exp_q.push_back({11'h11E, 8'h11});
        exp_q.push_back({11'h11F, 8'h22});
        exp_q.push_back({11'h110, 8'h33});
        wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
        pc = prog_cnt;
        do_stop();
        chk("R5 page wrap drained", exp_q.size(), 0);
        chk("R7 page prog", prog_cnt - pc, 1);

        // busy: polling gets no acknowledge
        prog_busy = 1;
        pc = prog_cnt;
        do_start();
        wr_byte(8'hA2, a); chk("R6 busy ctrl no ack", a, 0);
        wr_byte(8'h00, a); chk("R6 busy byte no ack", a, 0);
        do_stop();
        prog_busy = 0;
        chk("R6 busy no prog", prog_cnt - pc, 0);

        // address only, then STOP
        do_start();
        wr_byte(8'hA0, a); wr_byte(8'h10, a);
        do_stop();
        chk("R7 no data no prog", prog_cnt - pc, 0);

        // random read at 7FE, sequential across the top
        do_start();
        wr_byte(8'hAE, a); wr_byte(8'hFE, a);
        do_start();
        wr_byte(8'hAF, a); chk("R9 reread ctrl ack", a, 1);
        rd_byte(1, d); chk("R9 random read", d, seed('h7FE));
        rd_byte(1, d); chk("R10 sequential", d, seed('h7FF));
        rd_byte(0, d); chk("R10 wrap to 000", d, seed(0));
        chk("R10 release on nack", sda_low, 0);
        wr_byte(8'hA0, a); chk("R10 ignored after nack", a, 0);
        do_stop();
        chk("R9 no prog", prog_cnt - pc, 0);

        // wrong device code
        do_start();
        wr_byte(8'h9A, a); chk("R2 bad code no ack", a, 0);
        wr_byte(8'h55, a); chk("R2 ignored byte", a, 0);
        do_stop();
        do_start();
        wr_byte(8'hA0, a); chk("R2 recover after start", a, 1);
        do_stop();

        // write protect
        wp = 1;
        do_start();
        wr_byte(8'hA0, a); wr_byte(8'h40, a);
        wr_byte(8'h77, a); chk("R11 wp data ack", a, 1);
        do_stop();
        chk("R11 wp no prog", prog_cnt - pc, 0);
        do_start();
        wr_byte(8'hA0, a); wr_byte(8'h40, a);
        do_start();
        wr_byte(8'hA1, a);
        rd_byte(0, d); chk("R11 wp read unchanged", d, seed('h40));
        do_stop();
        wp = 0;
        chk("R11 no stray writes", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule